// File: doc/BRIEF.md
# Selectable-Source Cascaded Clock Divider

This block derives one clock from a choice of four incoming clocks. A single 32-bit configuration word picks the source, a power-of-two prescale step and an integer divide step. The chosen source is first divided by 2^shift and then by N+1. The result drives `clk_out`.

Switching between sources is glitch-free. The running source is gated off while it is low, and only then is the new one gated on. Each source has its own two-flop synchroniser on the request. A new prescale or divide setting is held back until the current output period has finished, so a reconfiguration never cuts a pulse short. Software writes the word through a plain write port with byte-lane enables and reads it back combinationally.

Top module: `clksel_div`

## Requirements
- R1: Bits 17:16 of the configuration word select the source index 0 to 3, and the output is derived from `src_clk[index]`.
- R2: Bits 5:4 hold a shift s, and the selected source is divided by 2^s (1, 2, 4 or 8) before the integer stage.
- R3: Bits 12:8 hold N, and the integer stage divides by N+1 (1 to 32).
- R4: The output period is 2^s·(N+1) source periods. For N>0 the high time is floor((N+1)/2)·2^s source periods and the rest of the period is low.
- R5: With N=0 the output equals the prescaled clock: the source itself when s=0, otherwise a 50% clock of period 2^s.
- R6: A write updates only the bits whose byte lane is enabled in `reg_be` (lane k covers bits 8k+7:8k). Lane 2 holds the select field, lane 0 the shift field and lane 1 the divide field, so a select-only write keeps shift and divide unchanged, and the other way round.
- R7: All bits outside 17:16, 12:8 and 5:4 read as zero and ignore writes.
- R8: Source switches and ratio changes never produce a high or low pulse shorter than half a period of the fastest source, and at most one source gate is open at any time.
- R9: A new ratio takes effect only at the end of the output period that is running when it is written.
- R10: While `rst_n` is low, the word reads zero, source 0 is gated on and the output follows source 0 undivided.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | NUM_SRC (4) | Candidate source clocks |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| reg_clk | input | 1 | Clock of the configuration write port |
| reg_wr | input | 1 | Write strobe, sampled on rising `reg_clk` |
| reg_be | input | DATA_W/8 (4) | Byte-lane write enables |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Current configuration word |
| clk_out | output | 1 | Divided clock |

## Verification
The checks on the switching handshake assume that every source keeps toggling while it is being switched away from or towards. Without that, the old gate can never close and the new one can never open. The bench keeps all four sources free-running with fixed, distinct periods. The divider-side checks assume the configuration word stays still for a short while around each output period boundary, because the fields cross clock domains without a handshake. The bench therefore writes once and then waits several microseconds, which is longer than the longest period, before it measures. Reset is applied only as a deliberate step, and the runt-pulse monitor is paused during that step.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
   localparam int DATA_W  = 32;
   localparam int NUM_SRC = 4;
   localparam int SEL_W   = 2;
   localparam int PRE_W   = 2;
   localparam int DIV_W   = 5;
   // field positions; a software neighbour decodes these
   localparam int SEL_LSB = 16;
   localparam int PRE_LSB = 4;
   localparam int DIV_LSB = 8;
endpackage

// File: rtl/cdiv_regs.sv
`timescale 1ns/1ps
module cdiv_regs
   import cdiv_pkg::*;
#(
   parameter int D_W   = DATA_W,
   parameter int S_W   = SEL_W,
   parameter int P_W   = PRE_W,
   parameter int N_W   = DIV_W,
   parameter int S_LSB = SEL_LSB,
   parameter int P_LSB = PRE_LSB,
   parameter int N_LSB = DIV_LSB
) (
   input  logic             reg_clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [D_W/8-1:0] be,
   input  logic [D_W-1:0]   wdata,
   output logic [D_W-1:0]   rdata,
   output logic [S_W-1:0]   sel,
   output logic [P_W-1:0]   pre,
   output logic [N_W-1:0]   div
);
   localparam logic [D_W-1:0] S_MASK = {{(D_W-S_W){1'b0}}, {S_W{1'b1}}} << S_LSB;
   localparam logic [D_W-1:0] P_MASK = {{(D_W-P_W){1'b0}}, {P_W{1'b1}}} << P_LSB;
   localparam logic [D_W-1:0] N_MASK = {{(D_W-N_W){1'b0}}, {N_W{1'b1}}} << N_LSB;
   localparam logic [D_W-1:0] LIVE   = S_MASK | P_MASK | N_MASK;

   initial begin
      assert (D_W % 8 == 0) else $error("data width must be whole bytes");
      assert (S_LSB + S_W <= D_W && P_LSB + P_W <= D_W && N_LSB + N_W <= D_W)
         else $error("field outside word");
      assert ((S_MASK & P_MASK) == '0 && (S_MASK & N_MASK) == '0 && (P_MASK & N_MASK) == '0)
         else $error("fields overlap");
   end

   logic [D_W-1:0] wmask;
   logic [D_W-1:0] word_q;

   always_comb begin
      for (int b = 0; b < D_W; b++) wmask[b] = be[b/8];
   end

   always_ff @(posedge reg_clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (wr)  word_q <= (word_q & ~(wmask & LIVE)) | (wdata & wmask & LIVE);
   end

   assign rdata = word_q;
   assign sel   = word_q[S_LSB +: S_W];
   assign pre   = word_q[P_LSB +: P_W];
   assign div   = word_q[N_LSB +: N_W];

   assert_sel_kept_R6: assert property (@(posedge reg_clk) disable iff (!rst_n)
      !(wr && |(wmask & S_MASK)) |=> $stable(sel));
   assert_ratio_kept_R6: assert property (@(posedge reg_clk) disable iff (!rst_n)
      !(wr && |(wmask & (P_MASK | N_MASK))) |=> ($stable(pre) && $stable(div)));
endmodule

// File: rtl/cdiv_gfmux.sv
`timescale 1ns/1ps
module cdiv_gfmux
   import cdiv_pkg::*;
#(
   parameter int N_SRC = NUM_SRC,
   parameter int S_W   = SEL_W
) (
   input  logic [N_SRC-1:0] src_clk,
   input  logic             rst_n,
   input  logic [S_W-1:0]   sel,
   output logic             mux_clk
);
   initial begin
      assert (N_SRC >= 2 && N_SRC <= (1 << S_W)) else $error("select too narrow");
   end

   logic [N_SRC-1:0] gate_q;
   logic [N_SRC-1:0] req;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      localparam logic ON_AT_RST = (i == 0);
      logic sync1_q, sync2_q, gate_r;

      // ask for this source only once every other gate has closed
      assign req[i] = (sel == S_W'(i)) && !(|(gate_q & ~(N_SRC'(1) << i)));

      always_ff @(posedge src_clk[i] or negedge rst_n) begin
         if (!rst_n) begin
            sync1_q <= ON_AT_RST;
            sync2_q <= ON_AT_RST;
         end else begin
            sync1_q <= req[i];
            sync2_q <= sync1_q;
         end
      end

      // gate changes while this source is low
      always_ff @(negedge src_clk[i] or negedge rst_n) begin
         if (!rst_n) gate_r <= ON_AT_RST;
         else        gate_r <= sync2_q;
      end

      assign gate_q[i] = gate_r;

      assert_one_gate_R8: assert property (@(posedge src_clk[i]) disable iff (!rst_n)
         $onehot0(gate_q));
   end

   assign mux_clk = |(src_clk & gate_q);
endmodule

// File: rtl/cdiv_divider.sv
`timescale 1ns/1ps
module cdiv_divider
   import cdiv_pkg::*;
#(
   parameter int P_W = PRE_W,
   parameter int N_W = DIV_W
) (
   input  logic           clk_in,
   input  logic           rst_n,
   input  logic [P_W-1:0] pre,
   input  logic [N_W-1:0] div,
   output logic           clk_out
);
   localparam int SHIFT_MAX = (1 << P_W) - 1;
   localparam int T_W       = N_W + SHIFT_MAX + 1;

   initial begin
      assert (P_W >= 1 && P_W <= 3) else $error("prescale width out of range");
      assert (N_W >= 1 && T_W <= 24) else $error("total ratio too wide");
   end

   logic [T_W-1:0] m_ratio, nxt_tot, nxt_hi;
   logic [T_W-1:0] act_tot, act_hi, cnt;
   logic           wrap, div_q, byp_q;

   always_comb begin
      m_ratio = T_W'(div) + T_W'(1);
      nxt_tot = m_ratio << pre;
      if (m_ratio == T_W'(1)) nxt_hi = nxt_tot >> 1;
      else                    nxt_hi = (m_ratio >> 1) << pre;
   end

   assign wrap = (cnt == act_tot - T_W'(1));

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         act_tot <= T_W'(1);
         act_hi  <= '0;
         div_q   <= 1'b1;
         byp_q   <= 1'b1;
      end else if (wrap) begin
         cnt     <= '0;
         act_tot <= nxt_tot;
         act_hi  <= nxt_hi;
         div_q   <= 1'b1;
         byp_q   <= (nxt_tot == T_W'(1));
      end else begin
         cnt     <= cnt + T_W'(1);
         div_q   <= (cnt + T_W'(1)) < act_hi;
      end
   end

   // both inputs of this mux change only at a rising clk_in edge
   assign clk_out = byp_q ? clk_in : div_q;

   assert_load_on_boundary_R9: assert property (@(posedge clk_in) disable iff (!rst_n)
      !$stable(act_tot) |-> (cnt == '0));
   assert_count_in_period_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
      cnt < act_tot);
   assert_high_length_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
      (!byp_q && $fell(div_q)) |-> (cnt == act_hi));
endmodule

// File: rtl/clksel_div.sv
`timescale 1ns/1ps
module clksel_div
   import cdiv_pkg::*;
#(
   parameter int D_W   = DATA_W,
   parameter int N_SRC = NUM_SRC,
   parameter int S_W   = SEL_W,
   parameter int P_W   = PRE_W,
   parameter int N_W   = DIV_W
) (
   input  logic [N_SRC-1:0] src_clk,
   input  logic             rst_n,
   input  logic             reg_clk,
   input  logic             reg_wr,
   input  logic [D_W/8-1:0] reg_be,
   input  logic [D_W-1:0]   reg_wdata,
   output logic [D_W-1:0]   reg_rdata,
   output logic             clk_out
);
   logic [S_W-1:0] sel;
   logic [P_W-1:0] pre;
   logic [N_W-1:0] div;
   logic           mux_clk;

   cdiv_regs #(
      .D_W(D_W), .S_W(S_W), .P_W(P_W), .N_W(N_W),
      .S_LSB(SEL_LSB), .P_LSB(PRE_LSB), .N_LSB(DIV_LSB)
   ) i_regs (
      .reg_clk(reg_clk), .rst_n(rst_n), .wr(reg_wr), .be(reg_be),
      .wdata(reg_wdata), .rdata(reg_rdata), .sel(sel), .pre(pre), .div(div)
   );

   cdiv_gfmux #(.N_SRC(N_SRC), .S_W(S_W)) i_mux (
      .src_clk(src_clk), .rst_n(rst_n), .sel(sel), .mux_clk(mux_clk)
   );

   cdiv_divider #(.P_W(P_W), .N_W(N_W)) i_div (
      .clk_in(mux_clk), .rst_n(rst_n), .pre(pre), .div(div), .clk_out(clk_out)
   );
endmodule

// File: tb/test_clksel_div.sv
`timescale 1ns/1ps
module test_clksel_div;
   logic clk = 1'b0, sa = 1'b0, sb = 1'b0, sc = 1'b0;
   always #4 clk = ~clk;   // 125 MHz, also source 0
   always #5 sa  = ~sa;    // source 1: 10 ns
   always #7 sb  = ~sb;    // source 2: 14 ns
   always #3 sc  = ~sc;    // source 3: 6 ns

   logic [3:0]  src;
   logic        rst_n, reg_wr, clk_out;
   logic [3:0]  reg_be;
   logic [31:0] reg_wdata, reg_rdata;
   assign src = {sc, sb, sa, clk};

   clksel_div i_clksel_div (
      .src_clk(src), .rst_n(rst_n), .reg_clk(clk), .reg_wr(reg_wr),
      .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out)
   );

   typedef struct { real per; real hi; string req; } exp_t;
   exp_t exp_q[$];
   real  src_per [4] = '{8.0, 10.0, 14.0, 6.0};
   int   n_chk = 0, n_fail = 0, runts = 0;
   bit   runt_en = 1'b0;

   task automatic chk_word(string r, logic [31:0] act, logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: read 0x%08h expected 0x%08h", r, act, expv);
      end
   endtask

   task automatic chk_time(string r, string what, real act, real expv);
      n_chk++;
      if (act - expv > 0.01 || expv - act > 0.01) begin
         n_fail++;
         $display("FAIL %s: %s %0.3f ns expected %0.3f ns", r, what, act, expv);
      end
   endtask

   task automatic wr(logic [3:0] be, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_be = be; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(string r, logic [31:0] expv);
      @(negedge clk);
      chk_word(r, reg_rdata, expv);
   endtask

   task automatic cfg(int s, int sh, int n);
      wr(4'hF, (32'(s) << 16) | (32'(n) << 8) | (32'(sh) << 4));
   endtask

   // driver side of the scoreboard
   task automatic expect_clk(int s, int sh, int n, string r);
      exp_t e;
      int m = n + 1;
      int p = 1 << sh;
      #8000;
      e.per = src_per[s] * m * p;
      e.hi  = (m == 1) ? e.per / 2.0 : (m / 2) * p * src_per[s];
      e.req = r;
      exp_q.push_back(e);
      wait (exp_q.size() == 0);
   endtask

   // monitor side: measure one full output period per queued item
   initial forever begin
      real t0, t1, t2;
      exp_t e;
      wait (exp_q.size() > 0);
      @(posedge clk_out); t0 = $realtime;
      @(negedge clk_out); t1 = $realtime;
      @(posedge clk_out); t2 = $realtime;
      e = exp_q[0];
      chk_time(e.req, "period", t2 - t0, e.per);
      chk_time(e.req, "high time", t1 - t0, e.hi);
      void'(exp_q.pop_front());
   end

   // runt monitor (R8)
   initial begin
      real last = -1.0;
      forever begin
         @(clk_out);
         if (runt_en && last >= 0.0 && ($realtime - last) < 2.9) runts++;
         last = $realtime;
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #1000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      finish_run();
   end

   initial begin
      real ta, tb;
      rst_n = 1'b0; reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
      #50;
      rd_chk("R10 reset word", 32'h0);
      expect_clk(0, 0, 0, "R10 reset output");
      @(negedge clk); rst_n = 1'b1;
      #40; runt_en = 1'b1;

      cfg(0, 1, 0);  expect_clk(0, 1, 0, "R2 R5 prescale 2");
      cfg(0, 0, 2);  expect_clk(0, 0, 2, "R3 R4 odd ratio 3");
      cfg(1, 2, 3);  expect_clk(1, 2, 3, "R1 R2 R3 src1 x16");
      cfg(2, 3, 31); expect_clk(2, 3, 31, "R3 R4 max ratio");
      cfg(3, 0, 0);  expect_clk(3, 0, 0, "R1 R5 passthrough src3");
      cfg(3, 1, 4);  expect_clk(3, 1, 4, "R4 odd with prescale");

      wr(4'h4, 32'h0001_0000);
      rd_chk("R6 select-only write", 32'h0001_0410);
      expect_clk(1, 1, 4, "R6 R1 switch keeps ratio");

      wr(4'h3, 32'h0003_0100);
      rd_chk("R6 ratio-only write", 32'h0001_0100);
      expect_clk(1, 0, 1, "R6 ratio write keeps select");

      wr(4'hF, 32'hFFFF_FFFF);
      rd_chk("R7 unused bits zero", 32'h0003_1F30);
      expect_clk(3, 3, 31, "R7 all-ones write");

      cfg(0, 0, 31); expect_clk(0, 0, 31, "R9 setup");
      @(posedge clk_out); ta = $realtime;
      #20;
      wr(4'h2, 32'h0000_0100);
      @(posedge clk_out); tb = $realtime;
      chk_time("R9 running period kept", "period", tb - ta, 256.0);
      expect_clk(0, 0, 1, "R9 new ratio after boundary");

      runt_en = 1'b0;
      cfg(2, 1, 2);
      #500;
      rst_n = 1'b0;
      #20;
      rd_chk("R10 reset mid-run word", 32'h0);
      expect_clk(0, 0, 0, "R10 reset mid-run output");
      @(negedge clk); rst_n = 1'b1;
      #100;

      n_chk++;
      if (runts != 0) begin
         n_fail++;
         $display("FAIL R8: runt pulses %0d expected 0", runts);
      end
      finish_run();
   end
endmodule